// File: doc/BRIEF.md
# Autonomous Text Screen Serial Streamer

This block pushes the contents of a character screen buffer out of a single asynchronous serial transmit line, endlessly and without any processor involvement. A host drops character codes into an on-chip dual-clock memory through a simple write port on its own clock. On a separate transmit clock, a read sequencer walks the memory from the lowest to the highest address and feeds each byte to an 8N1 serializer. It then starts over at once.

Ahead of every pass over the memory, the sequencer sends a run of marker bytes of value 0xFF. A receiver looks for that run to tell where the screen begins. The transmit clock runs at sixteen times the baud rate, and the serializer uses it directly, with no enable. At a 14.7456 MHz clock the line carries 921600 baud. With the default 2 KB depth a full frame arrives roughly 44 times a second. An 8 KB screen (`ADDR_W` = 13) takes about 11 frames a second at that rate, so the whole-buffer resend rate depends on the depth chosen. The memory is also the clock-domain crossing. When a host write and a transmit read hit the same address in the same cycle, either byte may be sent.

Top module: `fbs_uart_streamer`

## Requirements
- R1: While `tx_rst` is high, and from reset until the first start bit, `txd` is high (idle level).
- R2: Each byte is sent as one start bit at 0, then eight data bits with bit 0 first, then one stop bit at 1.
- R3: Every bit on `txd` lasts exactly `TICKS` (default 16) cycles of `tx_clk`.
- R4: Every frame begins with `PRE_LEN` (default 16) consecutive bytes of value 0xFF.
- R5: After the marker run, the frame carries the memory bytes at addresses 0, 1, ... up to 2**`ADDR_W`-1, in increasing order.
- R6: Characters follow each other with no idle gap, inside a frame and across the frame boundary. Every start bit begins exactly 10*`TICKS` cycles after the previous one.
- R7: A rising `wr_clk` edge with `wr_en` high stores `wr_data` at `wr_addr`. With `wr_en` low the memory is unchanged.
- R8: A host write that completes before the transmit side fetches that address shows up in the very next frame.
- R9: Raising `tx_rst` in the middle of a character returns `txd` to high on the next `tx_clk` edge. After release, the stream restarts at the first marker byte, followed by address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Host write clock |
| wr_en | input | 1 | Host write strobe, active high |
| wr_addr | input | ADDR_W | Host write address (character position) |
| wr_data | input | 8 | Character code to store |
| tx_clk | input | 1 | Transmit clock, 16x the baud rate |
| tx_rst | input | 1 | Synchronous active-high reset, transmit domain |
| txd | output | 1 | Serial transmit line, idles high |

## Verification
The bench decodes the line at mid-bit and compares each byte against a scoreboard across two whole frames. It goes after three things:
- The seam between the last memory byte and the next marker run. A sequencer that inserts a dead cycle there, or that skips or repeats the wrap address, breaks the exact 160-cycle start-to-start spacing or shifts every byte after it.
- A host update made during the second frame's marker run. A design that fetches bytes too early, or latches the whole frame, would resend stale characters.
- A write attempted with the strobe low. A design that ignores `wr_en` would corrupt address 3.

A reset pulled in the middle of a character must leave the line high at once and restart at the first marker byte. A design that keeps its bit counter or address across reset would resume mid-frame instead.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    localparam int unsigned CHAR_W     = 8;
    localparam int unsigned FRAME_BITS = CHAR_W + 2;
    localparam logic [CHAR_W-1:0] SYNC_MARK = 8'hFF;
endpackage

// File: rtl/fbs_dpram.sv
module fbs_dpram #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    // host side: the write domain owns the array
    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            cells_q[wr_addr] <= wr_data;
        end
    end

    // transmit side: registered read, one cycle of latency
    always_ff @(posedge rd_clk) begin
        if (rd_en) begin
            rd_data_q <= cells_q[rd_addr];
        end
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/fbs_sequencer.sv
module fbs_sequencer
    import fbs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned PRE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [CHAR_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned TOTAL = PRE_LEN + DEPTH;
    localparam int unsigned CW    = $clog2(TOTAL);

    typedef struct packed {
        logic [CW-1:0]     pos;      // next frame slot to fetch
        logic              valid;    // staged byte ready for serializer
        logic              pending;  // memory read in flight
        logic              pre;      // staged byte is a marker
        logic [CHAR_W-1:0] data;
    } seq_t;

    localparam seq_t SEQ_RST = '{pos: '0, valid: 1'b0, pending: 1'b0,
                                 pre: 1'b0, data: '0};

    seq_t seq_d, seq_q;
    logic consumed;
    logic slot_free;
    logic in_pre;
    logic [CW-1:0] rel_pos;

    always_comb begin
        seq_d     = seq_q;
        consumed  = seq_q.valid && out_ready;
        slot_free = !seq_q.valid || consumed;
        in_pre    = seq_q.pos < CW'(PRE_LEN);
        rel_pos   = seq_q.pos - CW'(PRE_LEN);
        rd_en     = 1'b0;
        rd_addr   = rel_pos[ADDR_W-1:0];

        if (consumed) begin
            seq_d.valid = 1'b0;
        end

        if (seq_q.pending) begin
            seq_d.data    = rd_data;
            seq_d.valid   = 1'b1;
            seq_d.pending = 1'b0;
        end else if (slot_free) begin
            if (in_pre) begin
                seq_d.data  = SYNC_MARK;
                seq_d.pre   = 1'b1;
                seq_d.valid = 1'b1;
            end else begin
                rd_en         = 1'b1;
                seq_d.pre     = 1'b0;
                seq_d.pending = 1'b1;
                seq_d.valid   = 1'b0;
            end
            seq_d.pos = (seq_q.pos == CW'(TOTAL - 1)) ? '0 : seq_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign out_valid = seq_q.valid;
    assign out_data  = seq_q.data;

    AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        seq_q.pending |=> seq_q.valid && !seq_q.pending); // R5
    AST_PRE_MARK: assert property (@(posedge clk) disable iff (rst)
        (seq_q.valid && seq_q.pre) |-> (out_data == SYNC_MARK)); // R4
    AST_HOLD_STAGED: assert property (@(posedge clk) disable iff (rst)
        (seq_q.valid && !out_ready) |=> (seq_q.valid && $stable(out_data))); // R5
endmodule

// File: rtl/fbs_serializer.sv
module fbs_serializer
    import fbs_pkg::*;
#(
    parameter int unsigned TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              in_ready,
    output logic              char_end,
    output logic              txd
);
    localparam int unsigned TW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam int unsigned BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] frame;   // bit 0 drives the line
        logic [BW-1:0]         bit_idx;
        logic [TW-1:0]         tick;
    } ser_t;

    localparam ser_t SER_RST = '{busy: 1'b0, frame: {FRAME_BITS{1'b1}},
                                 bit_idx: '0, tick: '0};

    ser_t ser_d, ser_q;
    logic last_tick;
    logic accept;

    always_comb begin
        ser_d     = ser_q;
        last_tick = ser_q.tick == TW'(TICKS - 1);
        char_end  = ser_q.busy && last_tick && (ser_q.bit_idx == LAST_BIT);
        in_ready  = !ser_q.busy || char_end;
        accept    = in_valid && in_ready;

        if (ser_q.busy) begin
            ser_d.tick = last_tick ? '0 : ser_q.tick + 1'b1;
            if (last_tick) begin
                if (ser_q.bit_idx == LAST_BIT) begin
                    ser_d.busy    = 1'b0;
                    ser_d.frame   = {FRAME_BITS{1'b1}};
                    ser_d.bit_idx = '0;
                end else begin
                    ser_d.frame   = {1'b1, ser_q.frame[FRAME_BITS-1:1]};
                    ser_d.bit_idx = ser_q.bit_idx + 1'b1;
                end
            end
        end

        if (accept) begin
            ser_d.busy    = 1'b1;
            ser_d.frame   = {1'b1, in_data, 1'b0};
            ser_d.bit_idx = '0;
            ser_d.tick    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= SER_RST;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign txd = ser_q.frame[0];

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ser_q.busy && ser_q.tick != '0) |-> $stable(txd)); // R3
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (ser_q.busy && ser_q.bit_idx == '0) |-> !txd); // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ser_q.busy && ser_q.bit_idx == LAST_BIT) |-> txd); // R2
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !ser_q.busy |-> txd); // R1
endmodule

// File: rtl/fbs_uart_streamer.sv
module fbs_uart_streamer
    import fbs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned PRE_LEN = 16,
    parameter int unsigned TICKS   = 16
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              tx_clk,
    input  logic              tx_rst,
    output logic              txd
);
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [CHAR_W-1:0] rd_data;
    logic              stg_valid;
    logic [CHAR_W-1:0] stg_data;
    logic              ser_ready;
    logic              ser_char_end;

    fbs_dpram #(.ADDR_W(ADDR_W), .DATA_W(CHAR_W)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (tx_clk),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    fbs_sequencer #(.ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN)) u_seq (
        .clk       (tx_clk),
        .rst       (tx_rst),
        .out_ready (ser_ready),
        .out_valid (stg_valid),
        .out_data  (stg_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    fbs_serializer #(.TICKS(TICKS)) u_ser (
        .clk      (tx_clk),
        .rst      (tx_rst),
        .in_valid (stg_valid),
        .in_data  (stg_data),
        .in_ready (ser_ready),
        .char_end (ser_char_end),
        .txd      (txd)
    );

    // the next character must already be staged when the stop bit ends
    AST_NO_GAP: assert property (@(posedge tx_clk) disable iff (tx_rst)
        ser_char_end |-> stg_valid); // R6
    AST_RST_LINE: assert property (@(posedge tx_clk)
        $past(tx_rst) |-> txd); // R9
endmodule

// File: tb/sim_fbs_uart_streamer.sv
module sim_fbs_uart_streamer;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;
    localparam int PRE   = 16;
    localparam int TICKS = 16;
    localparam int CHAR  = 10 * TICKS;
    localparam int FRAME = PRE + DEPTH;

    logic tx_clk = 1'b0;
    logic wr_clk = 1'b0;
    logic tx_rst = 1'b1;
    logic wr_en  = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic txd;

    always #2 tx_clk = ~tx_clk;
    always #3 wr_clk = ~wr_clk;

    fbs_uart_streamer #(.ADDR_W(AW), .PRE_LEN(PRE), .TICKS(TICKS)) u0 (
        .wr_clk (wr_clk), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .tx_clk (tx_clk), .tx_rst (tx_rst), .txd (txd)
    );

    int n_cmp = 0;
    int n_bad = 0;
    longint cyc = 0;
    always @(posedge tx_clk) cyc++;

    logic [7:0] model [DEPTH];
    bit         upd [DEPTH];
    int exp_q[$];
    int mon_count = 0;
    bit mon_go = 1'b0;
    bit mon_done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge wr_clk);
        wr_en = 1'b0;
        model[a] = 8'(d);
    endtask

    task automatic get_byte(output logic [7:0] b, output longint t0);
        @(negedge tx_clk);
        while (txd !== 1'b0) @(negedge tx_clk);
        t0 = cyc;
        repeat (TICKS / 2) @(negedge tx_clk);
        check(txd === 1'b0, "R2 start bit", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (TICKS) @(negedge tx_clk);
            b[i] = txd;
        end
        repeat (TICKS) @(negedge tx_clk);
        check(txd === 1'b1, "R2 stop bit", int'(txd), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: decode two frames and compare against the scoreboard
    initial begin
        logic [7:0] b;
        longint t, prev;
        wait (mon_go);
        prev = 0;
        for (int k = 0; k < 2 * FRAME; k++) begin
            int p, e;
            string tag;
            get_byte(b, t);
            if (k > 0) check((t - prev) == CHAR, "R6 start spacing", int'(t - prev), CHAR);
            prev = t;
            p = k % FRAME;
            if (p < PRE) tag = "R4 marker";
            else if (k >= FRAME && upd[p - PRE]) tag = "R8 updated byte";
            else if (p - PRE == 3) tag = "R7 strobe-low write ignored";
            else tag = "R5 buffer byte";
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 scoreboard empty", int'(b), 0);
            end else begin
                e = exp_q.pop_front();
                check(int'(b) == e, tag, int'(b), e);
            end
            mon_count++;
        end
        mon_done = 1'b1;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge tx_clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", mon_count, 2 * FRAME);
        summary();
        $finish;
    end

    // driver
    initial begin
        logic [7:0] b;
        longint t;
        int n;
        for (int a = 0; a < DEPTH; a++) upd[a] = 1'b0;
        repeat (3) @(negedge tx_clk);
        check(txd === 1'b1, "R1 idle in reset", int'(txd), 1);

        for (int a = 0; a < DEPTH; a++) host_write(a, (a * 37 + 11) & 8'hFE);
        // strobe low: must not store
        @(negedge wr_clk);
        wr_en = 1'b0; wr_addr = AW'(3); wr_data = ~model[3];
        @(negedge wr_clk);

        for (int i = 0; i < PRE; i++) exp_q.push_back(8'hFF);
        for (int a = 0; a < DEPTH; a++) exp_q.push_back(model[a]);
        for (int i = 0; i < PRE; i++) exp_q.push_back(8'hFF);

        repeat (5) @(negedge tx_clk);
        check(txd === 1'b1, "R1 idle before release", int'(txd), 1);
        mon_go = 1'b1;
        tx_rst = 1'b0;

        // one bit width: start bit of a 0xFF marker is the only low bit
        while (txd !== 1'b0) @(negedge tx_clk);
        n = 0;
        while (txd === 1'b0) begin n++; @(negedge tx_clk); end
        check(n == TICKS, "R3 bit period", n, TICKS);

        // update during the second frame's marker run
        wait (mon_count >= FRAME + 1);
        host_write(0, 8'hA5); upd[0] = 1'b1;
        host_write(5, 8'h3C); upd[5] = 1'b1;
        host_write(DEPTH - 1, 8'h00); upd[DEPTH - 1] = 1'b1;
        for (int a = 0; a < DEPTH; a++) exp_q.push_back(model[a]);

        wait (mon_done);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        // reset in the middle of a character
        repeat (40) @(negedge tx_clk);
        tx_rst = 1'b1;
        @(negedge tx_clk);
        check(txd === 1'b1, "R9 line high after reset", int'(txd), 1);
        repeat (4) @(negedge tx_clk);
        check(txd === 1'b1, "R9 line held high in reset", int'(txd), 1);
        tx_rst = 1'b0;
        for (int k = 0; k <= PRE; k++) begin
            get_byte(b, t);
            if (k < PRE) check(b == 8'hFF, "R9 restart marker", int'(b), 8'hFF);
            else check(b == model[0], "R9 restart at address 0", int'(b), int'(model[0]));
        end

        summary();
        $finish;
    end
endmodule